// File: doc/BRIEF.md
# Write-Combining Store Pool

This block gathers uncacheable stores in a small pool of line-sized entries before they are sent on to memory. Each store brings an address, one word of data, per-byte enables, a memory-type flag (write-combining or strictly uncacheable) and the number of the hardware thread that issued it. A write-combining store that lands in a line already held open by the same thread is folded into that entry, so a run of narrow writes leaves as a single line write. An uncacheable store is never merged: it always gets an entry to itself and leaves as soon as it can.

Entries leave one at a time through a downstream valid/ready port as a full line address, line data and a byte mask. An entry may leave once every byte is valid, once it holds an uncacheable store, or while the flush input is high. Among ready entries the lowest index goes first, so drain order follows pool position and not program order. Two threads share the pool, and a thread may not take the last free entry while the other thread owns nothing, which keeps one entry in hand for each thread. The pool does not look at the cache and is never snooped.

Top module: `wcb_pool`

## Requirements
- R1: After reset `dn_valid` is low and `st_ready` is high for any store.
- R2: A write-combining store from thread T whose line matches a filling write-combining entry of thread T is merged into that entry and takes no new entry; a store from the other thread to the same line gets a separate entry.
- R3: When a merged store writes bytes that are already valid, the later data replaces the earlier data in those bytes.
- R4: An uncacheable store (`st_uc` = 1) always takes a new entry and drains as its own line write whose mask holds only that store's enabled bytes, even when another store targets the same line.
- R5: Byte b of `st_data` goes to line byte 8*`st_addr[5:3]` + b when `st_be[b]` is 1; `dn_addr` is the line address with its low 6 bits zero, and `dn_uc`/`dn_tid` give the entry's memory type and thread.
- R6: A write-combining entry whose 64 byte-valid bits are not all set does not drain while `flush` is low; an entry becomes drainable once all 64 bits are set.
- R7: New entries are taken lowest free index first, and while `flush` is high every filling entry becomes drainable, the lowest-indexed drainable entry leaving first.
- R8: While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_addr`, `dn_mask`, `dn_uc` and `dn_tid` hold their values.
- R9: A store that needs a new entry is refused (`st_ready` low) when it would take the last free entry and the other thread holds no entry.
- R10: With every entry occupied, a store that needs a new entry sees `st_ready` low, while a write-combining store that can merge still sees `st_ready` high; `st_ready` reflects the presented fields whatever `st_valid` is.
- R11: The entry drained by a handshake at clock edge h is free from edge h on, so a store refused for lack of room sees `st_ready` high in the cycle after h.
- R12: An uncacheable store accepted at clock edge k with no drain in progress raises `dn_valid` after edge k+1, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store would be taken this cycle |
| st_addr | input | ADDR_W | Store byte address; bits [5:3] pick the word in the line |
| st_data | input | 8*WORD_BYTES | Store data word |
| st_be | input | WORD_BYTES | Per-byte write enables |
| st_uc | input | 1 | 1 = uncacheable, 0 = write-combining |
| st_tid | input | 1 | Issuing thread |
| flush | input | 1 | Makes every filling entry drainable while high |
| dn_valid | output | 1 | Line write presented downstream |
| dn_ready | input | 1 | Downstream takes the line write |
| dn_addr | output | ADDR_W | Line address, low 6 bits zero |
| dn_data | output | 8*LINE_BYTES | Line data |
| dn_mask | output | LINE_BYTES | Valid-byte mask |
| dn_uc | output | 1 | Memory type of the drained entry |
| dn_tid | output | 1 | Thread of the drained entry |

## Verification
The bench rewrites one word twice with narrower enables, so a pool that kept the first data or widened the mask would send the wrong bytes; it also writes the same line from both threads and twice as uncacheable, where wrongful merging would show up as one drain instead of several. It fills the pool from one thread to catch a design that lets that thread take the last entry or refuses a store that could merge, and it holds the drain port stalled to catch a design that lets outputs move or frees entries late. Partial lines are left idle to catch early draining, and a flush over many entries checks the lowest-index-first order.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
   typedef enum logic [1:0] {
      ENT_FREE  = 2'd0,
      ENT_FILL  = 2'd1,
      ENT_DRAIN = 2'd2
   } ent_state_e;
endpackage

// File: rtl/wcb_entry.sv
module wcb_entry import wcb_pkg::*; #(
   parameter int unsigned LINE_W     = 26,
   parameter int unsigned LINE_BYTES = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_i,
   input  logic                    merge_i,
   input  logic                    start_i,
   input  logic                    done_i,
   input  logic [LINE_W-1:0]       line_i,
   input  logic                    uc_i,
   input  logic                    tid_i,
   input  logic [LINE_BYTES-1:0]   be_i,
   input  logic [LINE_BYTES*8-1:0] data_i,
   output ent_state_e              state_o,
   output logic [LINE_W-1:0]       line_o,
   output logic                    uc_o,
   output logic                    tid_o,
   output logic [LINE_BYTES*8-1:0] data_o,
   output logic [LINE_BYTES-1:0]   mask_o
);
   // control and byte-valid state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= ENT_FREE;
         line_o  <= '0;
         uc_o    <= 1'b0;
         tid_o   <= 1'b0;
         mask_o  <= '0;
      end else if (alloc_i) begin
         state_o <= ENT_FILL;
         line_o  <= line_i;
         uc_o    <= uc_i;
         tid_o   <= tid_i;
         mask_o  <= be_i;
      end else begin
         if (merge_i) mask_o <= mask_o | be_i;
         if (start_i)     state_o <= ENT_DRAIN;
         else if (done_i) state_o <= ENT_FREE;
      end
   end

   // data bytes: a later write simply replaces the byte (collapse)
   always_ff @(posedge clk) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
         if ((alloc_i || merge_i) && be_i[b]) data_o[b*8 +: 8] <= data_i[b*8 +: 8];
      end
   end
endmodule

// File: rtl/wcb_alloc.sv
module wcb_alloc #(
   parameter int unsigned ENTRIES = 10,
   parameter int unsigned LINE_W  = 26
) (
   input  logic [ENTRIES-1:0]             occ_i,
   input  logic [ENTRIES-1:0]             fill_i,
   input  logic [ENTRIES-1:0]             uc_i,
   input  logic [ENTRIES-1:0]             tid_i,
   input  logic [ENTRIES-1:0][LINE_W-1:0] line_i,
   input  logic                           st_valid_i,
   input  logic [LINE_W-1:0]              st_line_i,
   input  logic                           st_uc_i,
   input  logic                           st_tid_i,
   output logic                           st_ready_o,
   output logic [ENTRIES-1:0]             hit_o,
   output logic [ENTRIES-1:0]             merge_o,
   output logic [ENTRIES-1:0]             alloc_o
);
   localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

   logic [ENTRIES-1:0] first_free;
   logic [CNT_W-1:0]   free_cnt;
   logic [CNT_W-1:0]   other_cnt;
   logic [CNT_W-1:0]   need_cnt;
   logic               hit_any;
   logic               room_ok;
   logic               take;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         hit_o[i] = fill_i[i] && !uc_i[i] && !st_uc_i &&
                    (tid_i[i] == st_tid_i) && (line_i[i] == st_line_i);
      end
   end

   always_comb begin
      logic found;
      found      = 1'b0;
      first_free = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!occ_i[i] && !found) begin
            first_free[i] = 1'b1;
            found         = 1'b1;
         end
      end
   end

   always_comb begin
      free_cnt  = '0;
      other_cnt = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         free_cnt  = free_cnt + CNT_W'(!occ_i[i]);
         other_cnt = other_cnt + CNT_W'(occ_i[i] && (tid_i[i] != st_tid_i));
      end
   end

   // keep one entry back for the other thread while it owns nothing
   assign need_cnt   = (other_cnt == '0) ? CNT_W'(2) : CNT_W'(1);
   assign room_ok    = (free_cnt >= need_cnt);
   assign hit_any    = |hit_o;
   assign st_ready_o = hit_any || room_ok;
   assign take       = st_valid_i && st_ready_o;
   assign merge_o    = (take && hit_any)  ? hit_o      : '0;
   assign alloc_o    = (take && !hit_any) ? first_free : '0;
endmodule

// File: rtl/wcb_drain.sv
module wcb_drain #(
   parameter int unsigned ENTRIES = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ENTRIES-1:0]         fill_i,
   input  logic [ENTRIES-1:0]         full_i,
   input  logic [ENTRIES-1:0]         uc_i,
   input  logic                       flush_i,
   input  logic                       dn_ready_i,
   output logic                       busy_o,
   output logic [$clog2(ENTRIES)-1:0] idx_o,
   output logic [ENTRIES-1:0]         start_o,
   output logic [ENTRIES-1:0]         done_o
);
   localparam int unsigned IDX_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] elig;
   logic [ENTRIES-1:0] pick;
   logic [IDX_W-1:0]   pick_idx;

   assign elig = fill_i & (full_i | uc_i | {ENTRIES{flush_i}});

   always_comb begin
      logic found;
      found    = 1'b0;
      pick     = '0;
      pick_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (elig[i] && !found) begin
            pick[i]  = 1'b1;
            pick_idx = IDX_W'(i);
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         idx_o  <= '0;
      end else if (busy_o) begin
         if (dn_ready_i) busy_o <= 1'b0;
      end else if (|elig) begin
         busy_o <= 1'b1;
         idx_o  <= pick_idx;
      end
   end

   assign start_o = busy_o ? '0 : pick;

   always_comb begin
      done_o = '0;
      if (busy_o && dn_ready_i) done_o[idx_o] = 1'b1;
   end
endmodule

// File: rtl/wcb_pool.sv
module wcb_pool import wcb_pkg::*; #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   parameter int unsigned WORD_BYTES = 8,
   parameter int unsigned ENTRIES    = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   output logic                    st_ready,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [WORD_BYTES*8-1:0] st_data,
   input  logic [WORD_BYTES-1:0]   st_be,
   input  logic                    st_uc,
   input  logic                    st_tid,
   input  logic                    flush,
   output logic                    dn_valid,
   input  logic                    dn_ready,
   output logic [ADDR_W-1:0]       dn_addr,
   output logic [LINE_BYTES*8-1:0] dn_data,
   output logic [LINE_BYTES-1:0]   dn_mask,
   output logic                    dn_uc,
   output logic                    dn_tid
);
   localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
   localparam int unsigned WOFS_W = $clog2(WORD_BYTES);
   localparam int unsigned WSEL_W = OFS_W - WOFS_W;
   localparam int unsigned LINE_W = ADDR_W - OFS_W;
   localparam int unsigned IDX_W  = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("wcb_pool: ENTRIES must be at least 2");
      end
      if ((1 << OFS_W) != LINE_BYTES || (1 << WOFS_W) != WORD_BYTES) begin : g_bad_pow2
         $error("wcb_pool: LINE_BYTES and WORD_BYTES must be powers of two");
      end
      if (LINE_BYTES <= WORD_BYTES || ADDR_W <= OFS_W) begin : g_bad_sizes
         $error("wcb_pool: line must hold several words and fit in the address");
      end
   endgenerate

   logic [LINE_W-1:0]       st_line;
   logic [WSEL_W-1:0]       st_wsel;
   logic [LINE_BYTES-1:0]   wide_be;
   logic [LINE_BYTES*8-1:0] wide_data;
   logic                    unused_ofs;

   assign st_line    = st_addr[ADDR_W-1:OFS_W];
   assign st_wsel    = st_addr[OFS_W-1:WOFS_W];
   assign unused_ofs = ^st_addr[WOFS_W-1:0];
   assign wide_be    = {{(LINE_BYTES-WORD_BYTES){1'b0}}, st_be} << {st_wsel, {WOFS_W{1'b0}}};
   assign wide_data  = {{((LINE_BYTES-WORD_BYTES)*8){1'b0}}, st_data} << {st_wsel, {(WOFS_W+3){1'b0}}};

   ent_state_e                       ent_state [ENTRIES];
   logic [ENTRIES-1:0][LINE_W-1:0]   ent_line;
   logic [ENTRIES-1:0][LINE_BYTES*8-1:0] ent_data;
   logic [ENTRIES-1:0][LINE_BYTES-1:0]   ent_mask;
   logic [ENTRIES-1:0] ent_uc, ent_tid;
   logic [ENTRIES-1:0] occ_vec, fill_vec, full_vec;
   logic [ENTRIES-1:0] hit_vec, merge_vec, alloc_vec, start_vec, done_vec;
   logic [IDX_W-1:0]   drn_idx;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         wcb_entry #(.LINE_W(LINE_W), .LINE_BYTES(LINE_BYTES)) ent_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_i (alloc_vec[g]),
            .merge_i (merge_vec[g]),
            .start_i (start_vec[g]),
            .done_i  (done_vec[g]),
            .line_i  (st_line),
            .uc_i    (st_uc),
            .tid_i   (st_tid),
            .be_i    (wide_be),
            .data_i  (wide_data),
            .state_o (ent_state[g]),
            .line_o  (ent_line[g]),
            .uc_o    (ent_uc[g]),
            .tid_o   (ent_tid[g]),
            .data_o  (ent_data[g]),
            .mask_o  (ent_mask[g])
         );
         assign occ_vec[g]  = (ent_state[g] != ENT_FREE);
         assign fill_vec[g] = (ent_state[g] == ENT_FILL);
         assign full_vec[g] = &ent_mask[g];
      end
   endgenerate

   wcb_alloc #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) alloc_i (
      .occ_i      (occ_vec),
      .fill_i     (fill_vec),
      .uc_i       (ent_uc),
      .tid_i      (ent_tid),
      .line_i     (ent_line),
      .st_valid_i (st_valid),
      .st_line_i  (st_line),
      .st_uc_i    (st_uc),
      .st_tid_i   (st_tid),
      .st_ready_o (st_ready),
      .hit_o      (hit_vec),
      .merge_o    (merge_vec),
      .alloc_o    (alloc_vec)
   );

   wcb_drain #(.ENTRIES(ENTRIES)) drain_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_i     (fill_vec),
      .full_i     (full_vec),
      .uc_i       (ent_uc),
      .flush_i    (flush),
      .dn_ready_i (dn_ready),
      .busy_o     (dn_valid),
      .idx_o      (drn_idx),
      .start_o    (start_vec),
      .done_o     (done_vec)
   );

   assign dn_addr = {ent_line[drn_idx], {OFS_W{1'b0}}};
   assign dn_data = ent_data[drn_idx];
   assign dn_mask = ent_mask[drn_idx];
   assign dn_uc   = ent_uc[drn_idx];
   assign dn_tid  = ent_tid[drn_idx];
endmodule

// File: rtl/wcb_pool_chk.sv
module wcb_pool_chk #(
   parameter int unsigned ENTRIES    = 10,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  st_ready,
   input logic                  dn_valid,
   input logic                  dn_ready,
   input logic [ADDR_W-1:0]     dn_addr,
   input logic [LINE_BYTES-1:0] dn_mask,
   input logic                  dn_uc,
   input logic                  dn_tid,
   input logic [ENTRIES-1:0]    occ_i,
   input logic [ENTRIES-1:0]    tid_i,
   input logic [ENTRIES-1:0]    hit_i
);
   localparam int unsigned OFS_W = $clog2(LINE_BYTES);

   // R2: a store never finds two entries to merge into
   a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_i));

   // R5: drained writes are line aligned and carry at least one byte
   a_r5_aligned_line: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (dn_addr[OFS_W-1:0] == '0) && (dn_mask != '0));

   // R8: a stalled drain holds its outputs
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_addr) && $stable(dn_mask)
                                  && $stable(dn_uc) && $stable(dn_tid));

   // R9: a full pool always has entries from both threads
   a_r9_thread_reserve: assert property (@(posedge clk) disable iff (!rst_n)
      (&occ_i) |-> ($countones(occ_i & ~tid_i) != 0) && ($countones(occ_i & tid_i) != 0));

   // R10: a full pool refuses anything that cannot merge
   a_r10_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      ((&occ_i) && !(|hit_i)) |-> !st_ready);

   // R11: the drain slot is released in the cycle after the handshake
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_ready) |=> !dn_valid);
endmodule

bind wcb_pool wcb_pool_chk #(
   .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .st_ready (st_ready),
   .dn_valid (dn_valid),
   .dn_ready (dn_ready),
   .dn_addr  (dn_addr),
   .dn_mask  (dn_mask),
   .dn_uc    (dn_uc),
   .dn_tid   (dn_tid),
   .occ_i    (occ_vec),
   .tid_i    (ent_tid),
   .hit_i    (hit_vec)
);

// File: tb/wcb_pool_tb_top.sv
module wcb_pool_tb_top;
   localparam int AW = 32;
   localparam int LB = 64;
   localparam int WB = 8;
   localparam int NE = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n, st_valid, st_ready, st_uc, st_tid, flush;
   logic [AW-1:0]   st_addr;
   logic [WB*8-1:0] st_data;
   logic [WB-1:0]   st_be;
   logic            dn_valid, dn_ready, dn_uc, dn_tid;
   logic [AW-1:0]   dn_addr;
   logic [LB*8-1:0] dn_data;
   logic [LB-1:0]   dn_mask;

   wcb_pool #(.ADDR_W(AW), .LINE_BYTES(LB), .WORD_BYTES(WB), .ENTRIES(NE)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_uc(st_uc),
      .st_tid(st_tid), .flush(flush), .dn_valid(dn_valid), .dn_ready(dn_ready),
      .dn_addr(dn_addr), .dn_data(dn_data), .dn_mask(dn_mask), .dn_uc(dn_uc),
      .dn_tid(dn_tid)
   );

   typedef struct {
      logic [AW-1:0]   addr;
      logic [LB*8-1:0] data;
      logic [LB-1:0]   mask;
      logic            uc;
      logic            tid;
      string           req;
   } exp_t;

   exp_t            exp_q[$];
   int              checks = 0;
   int              errors = 0;
   logic [LB*8-1:0] m_data;
   logic [LB-1:0]   m_mask;

   function automatic logic [LB*8-1:0] bytes_of(logic [LB-1:0] m);
      logic [LB*8-1:0] r;
      for (int b = 0; b < LB; b++) r[b*8 +: 8] = {8{m[b]}};
      return r;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic m_clear();
      m_data = '0;
      m_mask = '0;
   endtask

   task automatic m_put(logic [AW-1:0] a, logic [63:0] d, logic [7:0] be);
      int w;
      w = int'(a[5:3]);
      for (int b = 0; b < WB; b++) begin
         if (be[b]) begin
            m_data[(w*8+b)*8 +: 8] = d[b*8 +: 8];
            m_mask[w*8+b]          = 1'b1;
         end
      end
   endtask

   task automatic push_exp(logic [AW-1:0] a, logic uc, logic tid, string req);
      exp_t e;
      e.addr = {a[AW-1:6], 6'd0};
      e.data = m_data;
      e.mask = m_mask;
      e.uc   = uc;
      e.tid  = tid;
      e.req  = req;
      exp_q.push_back(e);
   endtask

   task automatic do_store(logic tid, logic uc, logic [AW-1:0] a, logic [63:0] d, logic [7:0] be);
      int w;
      @(negedge clk);
      st_valid = 1'b1; st_tid = tid; st_uc = uc; st_addr = a; st_data = d; st_be = be;
      #1;
      w = 0;
      while (!st_ready && w < 300) begin
         @(negedge clk); #1; w++;
      end
      if (w >= 300) begin
         checks++; errors++;
         $display("FAIL R10 store to %h never accepted: actual ready 0 expected 1", a);
      end
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic probe_ready(logic tid, logic uc, logic [AW-1:0] a, logic exp, string req);
      @(negedge clk);
      st_valid = 1'b0; st_tid = tid; st_uc = uc; st_addr = a; st_be = 8'h01;
      #1;
      chk(st_ready === exp, req, "st_ready", 64'(st_ready), 64'(exp));
   endtask

   task automatic wait_empty();
      int w;
      w = 0;
      do begin @(negedge clk); #3; w++; end
      while ((exp_q.size() != 0 || dn_valid) && w < 500);
      chk(exp_q.size() == 0, "R7", "pending drains", 64'(exp_q.size()), 64'd0);
   endtask

   // monitor: compare every downstream handshake with the scoreboard
   initial begin
      forever begin
         @(negedge clk); #2;
         if (rst_n && dn_valid && dn_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R7 unexpected drain: actual addr %h expected none", dn_addr);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (dn_addr !== e.addr || dn_mask !== e.mask || dn_uc !== e.uc ||
                   dn_tid !== e.tid ||
                   (dn_data & bytes_of(e.mask)) !== (e.data & bytes_of(e.mask))) begin
                  errors++;
                  $display("FAIL %s drain: actual addr %h mask %h uc %0d tid %0d data %h expected addr %h mask %h uc %0d tid %0d data %h",
                           e.req, dn_addr, dn_mask, dn_uc, dn_tid, dn_data & bytes_of(e.mask),
                           e.addr, e.mask, e.uc, e.tid, e.data & bytes_of(e.mask));
               end
            end
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [AW-1:0] held;
      rst_n = 1'b0; st_valid = 1'b0; st_uc = 1'b0; st_tid = 1'b0; flush = 1'b0;
      st_addr = '0; st_data = '0; st_be = '0; dn_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk); #1;
      chk(dn_valid === 1'b0, "R1", "dn_valid", 64'(dn_valid), 64'd0);
      chk(st_ready === 1'b1, "R1", "st_ready", 64'(st_ready), 64'd1);

      // R2 R3 R5 R6: one line built from many stores with a rewrite
      m_clear();
      do_store(0, 0, 32'h1000, 64'h1716151413121110, 8'hFF); m_put(32'h1000, 64'h1716151413121110, 8'hFF);
      do_store(0, 0, 32'h1000, 64'hEEEEEEEEC3C2C1C0, 8'h0F); m_put(32'h1000, 64'hEEEEEEEEC3C2C1C0, 8'h0F);
      for (int w = 1; w < 7; w++) begin
         do_store(0, 0, 32'h1000 + 32'(w*8), 64'h0101010101010101 * 64'(w + 2), 8'hFF);
         m_put(32'h1000 + 32'(w*8), 64'h0101010101010101 * 64'(w + 2), 8'hFF);
      end
      repeat (4) @(negedge clk);
      #1 chk(dn_valid === 1'b0, "R6", "partial line drained", 64'(dn_valid), 64'd0);
      push_exp(32'h1000, 0, 0, "R3");
      do_store(0, 0, 32'h1038, 64'h8899AABBCCDDEEFF, 8'hFF); m_put(32'h1038, 64'h8899AABBCCDDEEFF, 8'hFF);
      exp_q[0].data = m_data; exp_q[0].mask = m_mask;
      wait_empty();

      // R12 R4: uncacheable stores to one line never merge
      @(negedge clk); dn_ready = 1'b0;
      do_store(1, 1, 32'h3010, 64'hA7A6A5A4A3A2A1A0, 8'hF0);
      @(negedge clk); #1 chk(dn_valid === 1'b0, "R12", "dn_valid one cycle after accept", 64'(dn_valid), 64'd0);
      @(negedge clk); #1 chk(dn_valid === 1'b1, "R12", "dn_valid two cycles after accept", 64'(dn_valid), 64'd1);
      do_store(1, 1, 32'h3010, 64'hB7B6B5B4B3B2B1B0, 8'hFF);
      m_clear(); m_put(32'h3010, 64'hA7A6A5A4A3A2A1A0, 8'hF0); push_exp(32'h3010, 1, 1, "R4");
      m_clear(); m_put(32'h3010, 64'hB7B6B5B4B3B2B1B0, 8'hFF); push_exp(32'h3010, 1, 1, "R4");
      @(negedge clk); dn_ready = 1'b1;
      wait_empty();

      // R2 R7 R6: per-thread lines, flush drains lowest index first
      do_store(0, 0, 32'h4000, 64'h00000000000000C1, 8'h01);
      do_store(1, 0, 32'h4008, 64'h00000000000000D2, 8'h01);
      do_store(0, 0, 32'h5018, 64'h000000000000E3E3, 8'h03);
      do_store(0, 0, 32'h4010, 64'h00000000000000F4, 8'h01);
      repeat (5) @(negedge clk);
      #1 chk(dn_valid === 1'b0, "R6", "partial lines idle", 64'(dn_valid), 64'd0);
      m_clear(); m_put(32'h4000, 64'hC1, 8'h01); m_put(32'h4010, 64'hF4, 8'h01); push_exp(32'h4000, 0, 0, "R2");
      m_clear(); m_put(32'h4008, 64'hD2, 8'h01); push_exp(32'h4008, 0, 1, "R2");
      m_clear(); m_put(32'h5018, 64'hE3E3, 8'h03); push_exp(32'h5018, 0, 0, "R7");
      @(negedge clk); flush = 1'b1;
      wait_empty();
      @(negedge clk); flush = 1'b0;

      // R9 R10: one thread fills the pool
      @(negedge clk); dn_ready = 1'b0;
      for (int i = 0; i < NE - 1; i++) begin
         do_store(0, 0, 32'h10000 + 32'(i*64), 64'(i + 16), 8'h01);
      end
      probe_ready(0, 0, 32'h20000, 1'b0, "R9");
      do_store(1, 0, 32'h30000, 64'h5A, 8'h01);
      probe_ready(1, 0, 32'h30040, 1'b0, "R10");
      probe_ready(1, 1, 32'h30000, 1'b0, "R10");
      probe_ready(0, 0, 32'h10008, 1'b1, "R10");
      do_store(0, 0, 32'h10008, 64'h6B, 8'h01);
      m_clear(); m_put(32'h10000, 64'd16, 8'h01); m_put(32'h10008, 64'h6B, 8'h01); push_exp(32'h10000, 0, 0, "R10");
      for (int i = 1; i < NE - 1; i++) begin
         m_clear(); m_put(32'h10000 + 32'(i*64), 64'(i + 16), 8'h01);
         push_exp(32'h10000 + 32'(i*64), 0, 0, "R7");
      end
      m_clear(); m_put(32'h30000, 64'h5A, 8'h01); push_exp(32'h30000, 0, 1, "R7");

      // R8 R11: stalled drain holds, freed entry usable after handshake
      @(negedge clk); flush = 1'b1;
      @(negedge clk); @(negedge clk); #1;
      chk(dn_valid === 1'b1, "R8", "dn_valid under flush", 64'(dn_valid), 64'd1);
      held = dn_addr;
      repeat (3) @(negedge clk);
      #1 chk(dn_valid === 1'b1 && dn_addr === held, "R8", "stalled dn_addr", 64'(dn_addr), 64'(held));
      probe_ready(1, 0, 32'h30040, 1'b0, "R11");
      dn_ready = 1'b1;
      @(negedge clk); dn_ready = 1'b0;
      #1 chk(st_ready === 1'b1, "R11", "st_ready after release", 64'(st_ready), 64'd1);
      @(negedge clk); dn_ready = 1'b1;
      wait_empty();
      @(negedge clk); flush = 1'b0;

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "leftover expected drains", 64'(exp_q.size()), 64'd0);
      finish_run();
   end
endmodule